// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This block is the interrupt front end of a general-purpose I/O unit with 32 input pins. The pins form a low group (pins 0–15) and a high group (pins 16–31). Each group has its own 16-bit configuration and status words on a simple word-addressed register bus. Every pin is synchronised to the clock. Each pin is then either level-detected, using a selectable active polarity, or edge-detected, using separately enabled rising and falling edges. A detected condition sets the pin's pending status bit. For an edge pin, a per-pin mode sets how long that bit lasts: in hold mode the bit stays set until software clears it, and in through mode it follows the detector.

Pending bits are gated by per-pin enables. A fixed-priority encoder turns the enabled pending set into one pin number and a combined request line. When nothing enabled is pending, it raises a spurious flag instead. Software acknowledges a held edge interrupt by writing a one to its status bit.

The register bus is a plain single-cycle strobe with no handshake. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. The interrupt outputs are plain level signals.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the enable words read 0, the type and hold words read 0, and the active-level, falling-enable and rising-enable words read 0xFFFF. All status bits are 0, `irq_req` is 0 and `irq_spurious` is 1.
- R2: Register word addresses are: 4/5 status, 6/7 enable, 8/9 type, 10/11 active level, 12/13 hold, 16/17 falling-edge enable, 18/19 rising-edge enable. An even address selects pins 0–15 and an odd address selects pins 16–31, with bit k meaning pin k of that group. Configuration words read back what was written. Any other address reads 0.
- R3: Each pin passes through two synchronising flops. A level change driven before clock edge 1 shows in the status bit after edge 3, and not after edge 2.
- R4: A pin whose type bit is 0 is level-detected. Its status bit follows the synchronised pin when its active-level bit is 1, and follows the inverted pin when that bit is 0.
- R5: A pin whose type bit is 1 and hold bit is 1 sets its status bit on a detected edge. The bit then stays set after the pin returns to its idle state.
- R6: Writing 1 to a status bit clears a held edge status bit. Writing 0 leaves it unchanged. A new edge in the same cycle as the clear wins. On a level-detected pin whose condition is still present, the clear has no lasting effect.
- R7: A pin whose type bit is 1 and hold bit is 0 shows its status bit for exactly one cycle per detected edge.
- R8: An edge triggers only if its enable bit is set. With only the rising bit set, only rising edges count. With only the falling bit set, only falling edges count. With both set, both count.
- R9: `irq_req` is 1 exactly when some pin has both its status bit and its enable bit set. Enable bits do not alter status bits.
- R10: `irq_id` is the lowest-numbered enabled pending pin in the low group. If no low-group pin is enabled and pending, it is the lowest such pin in the high group, reported as index plus 16.
- R11: `irq_spurious` is 1 and `irq_id` is 0 whenever no enabled pin is pending, even if status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_in | input | 32 | Asynchronous GPIO inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Combined interrupt request |
| irq_id | output | 5 | Number of the highest-priority enabled pending pin |
| irq_spurious | output | 1 | No enabled pin is pending |

## Verification
The assertions check several rules on every cycle. A level pin's status tracks its synchronised input. A held edge bit survives until cleared and drops on a clear that has no competing edge. A through-mode bit falls once no edge is present. The enables come out of reset at zero. The reported pin number is always enabled, pending and lowest in priority order. Other behaviour can only be shown by the bench's scenarios, using its cycle model: the three-edge input latency, that a hold bit stays set across a full pulse, the one-cycle width of a through pulse, edge selection by direction, a clear that is overridden on a level pin, and the priority choice between low-group and high-group pins.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 5;
  localparam int FN_W = REG_ADDR_W - 1;

  // Register function: word address bits [4:1]; bit 0 picks the pin group.
  typedef enum logic [FN_W-1:0] {
    FN_STAT = 4'd2,
    FN_EN   = 4'd3,
    FN_TYPE = 4'd4,
    FN_LVL  = 4'd5,
    FN_HOLD = 4'd6,
    FN_FALL = 4'd8,
    FN_RISE = 4'd9
  } reg_fn_e;
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  // Stages 0..STAGES-1 synchronise; stage STAGES holds the previous value.
  logic [W-1:0] stg [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k <= STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign cur = stg[STAGES-1];
  assign prv = stg[STAGES];
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int GROUP_W = 16,
  localparam int N = 2 * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [GROUP_W-1:0]    wdata,
  input  logic [N-1:0]          stat,
  output logic [GROUP_W-1:0]    rdata,
  output logic [N-1:0]          en,
  output logic [N-1:0]          typ,
  output logic [N-1:0]          lvl,
  output logic [N-1:0]          hold,
  output logic [N-1:0]          fall_en,
  output logic [N-1:0]          rise_en,
  output logic [N-1:0]          clr
);
  logic [FN_W-1:0] fsel;
  logic            half;
  assign fsel = addr[REG_ADDR_W-1:1];
  assign half = addr[0];

  function automatic logic [GROUP_W-1:0] pick(input logic [N-1:0] v, input logic h);
    return h ? v[N-1:GROUP_W] : v[GROUP_W-1:0];
  endfunction

  function automatic logic [N-1:0] place(input logic [N-1:0] v, input logic h,
                                         input logic [GROUP_W-1:0] d);
    logic [N-1:0] r;
    r = v;
    if (h) r[N-1:GROUP_W] = d;
    else   r[GROUP_W-1:0] = d;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= '0;
      typ     <= '0;
      hold    <= '0;
      lvl     <= '1;
      fall_en <= '1;
      rise_en <= '1;
    end else if (wr) begin
      case (fsel)
        FN_EN:   en      <= place(en, half, wdata);
        FN_TYPE: typ     <= place(typ, half, wdata);
        FN_LVL:  lvl     <= place(lvl, half, wdata);
        FN_HOLD: hold    <= place(hold, half, wdata);
        FN_FALL: fall_en <= place(fall_en, half, wdata);
        FN_RISE: rise_en <= place(rise_en, half, wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    clr = '0;
    if (wr && fsel == FN_STAT) clr = place('0, half, wdata);
  end

  always_comb begin
    case (fsel)
      FN_STAT: rdata = pick(stat, half);
      FN_EN:   rdata = pick(en, half);
      FN_TYPE: rdata = pick(typ, half);
      FN_LVL:  rdata = pick(lvl, half);
      FN_HOLD: rdata = pick(hold, half);
      FN_FALL: rdata = pick(fall_en, half);
      FN_RISE: rdata = pick(rise_en, half);
      default: rdata = '0;
    endcase
  end

  // R1: enables come out of reset cleared
  a_r1_enable_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en == '0));

  // R2: a low-group enable write lands in the low half
  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    (wr && fsel == FN_EN && !half) |=> (en[GROUP_W-1:0] == $past(wdata)));
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prv,
  input  logic [N-1:0] typ,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] hold,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic edge_hit;
    logic level_hit;
    logic st_q;

    assign edge_hit  = (cur[i] & ~prv[i] & rise_en[i]) | (~cur[i] & prv[i] & fall_en[i]);
    assign level_hit = lvl[i] ? cur[i] : ~cur[i];

    always_ff @(posedge clk) begin
      if (rst)          st_q <= 1'b0;
      else if (!typ[i]) st_q <= level_hit;
      else if (hold[i]) st_q <= edge_hit | (st_q & ~clr[i]);
      else              st_q <= edge_hit;
    end

    assign stat[i] = st_q;

    // R4: active-high level pin mirrors the synchronised input one cycle later
    a_r4_level_tracks: assert property (@(posedge clk) disable iff (rst)
      (!typ[i] && lvl[i]) |=> (stat[i] == $past(cur[i])));

    // R5: held edge status survives while not cleared
    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (rst)
      (typ[i] && hold[i] && stat[i] && !clr[i]) |=> stat[i]);

    // R6: clear with no transition empties a held bit
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
      (typ[i] && hold[i] && clr[i] && (cur[i] == prv[i])) |=> !stat[i]);

    // R7: through mode drops when no transition is seen
    a_r7_through_drops: assert property (@(posedge clk) disable iff (rst)
      (typ[i] && !hold[i] && (cur[i] == prv[i])) |=> !stat[i]);
  end
endmodule

// File: rtl/gpio_irq_encoder.sv
`timescale 1ns/1ps
module gpio_irq_encoder #(
  parameter int GROUP_W = 16,
  localparam int N    = 2 * GROUP_W,
  localparam int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    stat,
  input  logic [N-1:0]    en,
  output logic            req,
  output logic [ID_W-1:0] id,
  output logic            spurious
);
  logic [GROUP_W-1:0] act_lo, act_hi;
  logic [N-1:0]       act_all, below;

  assign act_all = stat & en;
  assign act_lo  = act_all[GROUP_W-1:0];
  assign act_hi  = act_all[N-1:GROUP_W];

  always_comb begin
    id = '0;
    if (act_lo == '0) begin
      for (int k = GROUP_W - 1; k >= 0; k--)
        if (act_hi[k]) id = ID_W'(k + GROUP_W);
    end else begin
      for (int k = GROUP_W - 1; k >= 0; k--)
        if (act_lo[k]) id = ID_W'(k);
    end
  end

  assign req      = |act_all;
  assign spurious = ~req;
  assign below    = (N'(1) << id) - N'(1);

  // R10: reported pin is active and nothing of higher priority is active
  a_r10_priority: assert property (@(posedge clk) disable iff (rst)
    req |-> (act_all[id] && ((act_all & below) == '0)));

  // R11: spurious means no enabled pending pin and a zero number
  a_r11_spurious_empty: assert property (@(posedge clk) disable iff (rst)
    spurious |-> ((stat & en) == '0 && id == '0));

  // R9: a request is never raised from disabled bits alone
  a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> !req);
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int GROUP_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int N    = 2 * GROUP_W,
  localparam int ID_W = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          pins_in,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [GROUP_W-1:0]    reg_wdata,
  output logic [GROUP_W-1:0]    reg_rdata,
  output logic                  irq_req,
  output logic [ID_W-1:0]       irq_id,
  output logic                  irq_spurious
);
  logic [N-1:0] cur, prv, stat, en, typ, lvl, hold, fall_en, rise_en, clr;

  gpio_irq_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins_in), .cur(cur), .prv(prv)
  );

  gpio_irq_regs #(.GROUP_W(GROUP_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .stat(stat), .rdata(reg_rdata), .en(en), .typ(typ), .lvl(lvl),
    .hold(hold), .fall_en(fall_en), .rise_en(rise_en), .clr(clr)
  );

  gpio_irq_detect #(.N(N)) u_detect (
    .clk(clk), .rst(rst), .cur(cur), .prv(prv), .typ(typ), .lvl(lvl),
    .hold(hold), .fall_en(fall_en), .rise_en(rise_en), .clr(clr), .stat(stat)
  );

  gpio_irq_encoder #(.GROUP_W(GROUP_W)) u_enc (
    .clk(clk), .rst(rst), .stat(stat), .en(en),
    .req(irq_req), .id(irq_id), .spurious(irq_spurious)
  );
endmodule

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
  localparam int G = 16;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '0;
  logic          wr = 1'b0;
  logic [4:0]    addr = '0;
  logic [G-1:0]  wd = '0;
  logic [G-1:0]  rd;
  logic          req, spur;
  logic [4:0]    id;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  gpio_irq_unit uut (
    .clk(clk), .rst(rst), .pins_in(pins), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wd), .reg_rdata(rd), .irq_req(req), .irq_id(id), .irq_spurious(spur)
  );

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] m_s1, m_s, m_p, m_st, m_en, m_ty, m_lv, m_ho, m_fe, m_re;

  function automatic logic [N-1:0] put(input logic [N-1:0] v, input logic h, input logic [G-1:0] d);
    logic [N-1:0] r;
    r = v;
    if (h) r[N-1:G] = d; else r[G-1:0] = d;
    return r;
  endfunction

  function automatic logic [G-1:0] mread(input logic [4:0] a);
    logic [N-1:0] v;
    case (a[4:1])
      4'd2: v = m_st;
      4'd3: v = m_en;
      4'd4: v = m_ty;
      4'd5: v = m_lv;
      4'd6: v = m_ho;
      4'd8: v = m_fe;
      4'd9: v = m_re;
      default: v = '0;
    endcase
    return a[0] ? v[N-1:G] : v[G-1:0];
  endfunction

  function automatic int ref_id();
    logic [N-1:0] a;
    a = m_st & m_en;
    for (int i = 0; i < N; i++) if (a[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] nxt, clrv;
    logic evb;
    if (rst) begin
      m_s1 = '0; m_s = '0; m_p = '0; m_st = '0; m_en = '0; m_ty = '0;
      m_ho = '0; m_lv = '1; m_fe = '1; m_re = '1;
    end else begin
      clrv = '0;
      if (wr && addr[4:1] == 4'd2) clrv = put('0, addr[0], wd);
      for (int i = 0; i < N; i++) begin
        evb = (m_s[i] && !m_p[i] && m_re[i]) || (!m_s[i] && m_p[i] && m_fe[i]);
        if (!m_ty[i])     nxt[i] = m_lv[i] ? m_s[i] : !m_s[i];
        else if (m_ho[i]) nxt[i] = evb || (m_st[i] && !clrv[i]);
        else              nxt[i] = evb;
      end
      m_st = nxt; m_p = m_s; m_s = m_s1; m_s1 = pins;
      if (wr) begin
        case (addr[4:1])
          4'd3: m_en = put(m_en, addr[0], wd);
          4'd4: m_ty = put(m_ty, addr[0], wd);
          4'd5: m_lv = put(m_lv, addr[0], wd);
          4'd6: m_ho = put(m_ho, addr[0], wd);
          4'd8: m_fe = put(m_fe, addr[0], wd);
          4'd9: m_re = put(m_re, addr[0], wd);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison of the interrupt outputs (R9, R10, R11)
  always @(negedge clk) begin
    if (!rst) begin
      logic ereq;
      ereq = |(m_st & m_en);
      n_tests++;
      if (req !== ereq || spur !== !ereq || id !== 5'(ref_id())) begin
        n_fail++;
        $display("FAIL R9/R10/R11 cycle: req=%0b id=%0d spur=%0b exp req=%0b id=%0d spur=%0b",
                 req, id, spur, ereq, ref_id(), !ereq);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got 0x%0h exp 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrx(input logic [4:0] a, input logic [G-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wd = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rdx(input logic [4:0] a, output logic [G-1:0] v);
    @(negedge clk);
    wr = 1'b0; addr = a;
    #1 v = rd;
  endtask

  task automatic rdm(input string tag, input logic [4:0] a);
    logic [G-1:0] v;
    rdx(a, v);
    chk(tag, 32'(v), 32'(mread(a)));
  endtask

  task automatic rde(input string tag, input logic [4:0] a, input logic [G-1:0] e);
    logic [G-1:0] v;
    rdx(a, v);
    chk(tag, 32'(v), 32'(e));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int cnt;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    rde("R1 enable lo", 5'd6, 16'h0000);
    rde("R1 enable hi", 5'd7, 16'h0000);
    rde("R1 type lo", 5'd8, 16'h0000);
    rde("R1 hold hi", 5'd13, 16'h0000);
    rde("R1 level lo", 5'd10, 16'hFFFF);
    rde("R1 fall hi", 5'd17, 16'hFFFF);
    rde("R1 rise lo", 5'd18, 16'hFFFF);
    rde("R1 status lo", 5'd4, 16'h0000);
    chk("R1 req", 32'(req), 0);
    chk("R1 spurious", 32'(spur), 1);

    // R2 map and readback
    wrx(5'd9, 16'h1234);
    wrx(5'd12, 16'h00F0);
    rde("R2 type hi readback", 5'd9, 16'h1234);
    rde("R2 type lo untouched", 5'd8, 16'h0000);
    rde("R2 hold lo readback", 5'd12, 16'h00F0);
    rde("R2 unmapped reads 0", 5'd14, 16'h0000);
    rde("R2 unmapped addr 0", 5'd0, 16'h0000);
    wrx(5'd9, 16'h0000);
    wrx(5'd12, 16'h0000);

    // R3 latency on pin 5 (level, active high)
    @(negedge clk); addr = 5'd4;
    pins[5] = 1'b1;
    @(negedge clk); chk("R3 after edge1", 32'(rd[5]), 0);
    @(negedge clk); chk("R3 after edge2", 32'(rd[5]), 0);
    @(negedge clk); chk("R3 after edge3", 32'(rd[5]), 1);

    // R4 active-low on pin 6
    wrx(5'd10, 16'hFFBF);
    tick(4);
    rde("R4 active low + high", 5'd4, 16'h0060);
    pins[5] = 1'b0;
    tick(4);
    rde("R4 pin5 released", 5'd4, 16'h0040);
    wrx(5'd6, 16'h0040);
    tick(1);
    chk("R9 req with enable", 32'(req), 1);
    chk("R10 id pin6", 32'(id), 6);
    wrx(5'd10, 16'hFFFF);
    wrx(5'd6, 16'h0000);
    tick(4);
    rde("R4 restored", 5'd4, 16'h0000);

    // R5 hold edge on pin 20 (high group bit 4)
    wrx(5'd9, 16'h0010);
    wrx(5'd13, 16'h0010);
    @(negedge clk); pins[20] = 1'b1;
    @(negedge clk); pins[20] = 1'b0;
    tick(6);
    rde("R5 held after pulse", 5'd5, 16'h0010);

    // R6 write-one-to-clear
    wrx(5'd5, 16'h0000);
    rde("R6 zero write keeps", 5'd5, 16'h0010);
    wrx(5'd5, 16'h0010);
    rde("R6 one write clears", 5'd5, 16'h0000);
    pins[7] = 1'b1;
    tick(4);
    wrx(5'd4, 16'h0080);
    rde("R6 level clear no effect", 5'd4, 16'h0080);
    pins[7] = 1'b0;
    tick(4);

    // R7 through mode on pin 21
    wrx(5'd13, 16'h0000);
    wrx(5'd9, 16'h0030);
    @(negedge clk); addr = 5'd5; pins[21] = 1'b1;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (rd[5]) cnt++;
    end
    chk("R7 one-cycle pulse", 32'(cnt), 1);
    pins[21] = 1'b0;
    tick(4);
    wrx(5'd9, 16'h0000);
    tick(2);
    rdm("R7 status hi model", 5'd5);

    // R8 edge selection on pin 9
    wrx(5'd8, 16'h0200);
    wrx(5'd12, 16'h0200);
    wrx(5'd16, 16'hFDFF);
    pins[9] = 1'b1; tick(5);
    rde("R8 rise-only sees rise", 5'd4, 16'h0200);
    wrx(5'd4, 16'h0200);
    pins[9] = 1'b0; tick(5);
    rde("R8 rise-only ignores fall", 5'd4, 16'h0000);
    wrx(5'd16, 16'hFFFF);
    wrx(5'd18, 16'hFDFF);
    pins[9] = 1'b1; tick(5);
    rde("R8 fall-only ignores rise", 5'd4, 16'h0000);
    pins[9] = 1'b0; tick(5);
    rde("R8 fall-only sees fall", 5'd4, 16'h0200);
    wrx(5'd18, 16'hFFFF);
    wrx(5'd4, 16'h0200);
    wrx(5'd8, 16'h0000);
    wrx(5'd12, 16'h0000);
    tick(4);
    rdm("R8 status lo model", 5'd4);

    // R9..R11 encoder
    wrx(5'd6, 16'hFFFF);
    wrx(5'd7, 16'hFFFF);
    pins[30] = 1'b1; pins[3] = 1'b1;
    tick(5);
    chk("R10 low group first", 32'(id), 3);
    pins[3] = 1'b0;
    tick(5);
    chk("R10 high index plus 16", 32'(id), 30);
    pins[12] = 1'b1; pins[2] = 1'b1;
    tick(5);
    chk("R10 lowest pin wins", 32'(id), 2);
    wrx(5'd6, 16'hFFFB);
    tick(1);
    chk("R9 masked pin skipped", 32'(id), 12);
    rde("R9 enable keeps status", 5'd4, 16'h1004);
    wrx(5'd6, 16'h0000);
    wrx(5'd7, 16'h0000);
    tick(1);
    chk("R11 spurious set", 32'(spur), 1);
    chk("R11 id zero", 32'(id), 0);
    chk("R9 no req", 32'(req), 0);
    rde("R11 status still set", 5'd5, 16'h4000);
    pins = '0;
    tick(5);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule